// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Join Sequencer

This block decides when a backplane segment and a card segment of a two-wire serial bus (one clock line, one data line per segment) may be tied together after a card is inserted or the block is enabled. It samples the levels of all four lines through two-flop synchronisers. It then walks through an off state, an initialisation interval, and a watch state in which it waits for the bus to go quiet. When it decides to join, it raises the connection flags. The analog parts of such a device (buffers, thresholds, slew detection, precharge resistors) are outside this block. They appear here only as the digital controls that drive them.

Joining needs two things. First, the initialisation interval must have finished. Second, either all four lines must then have stayed high for a full bus-idle interval, or a STOP condition must appear on the backplane pair while every line is high. While joined, a low seen on one side of a pair is copied to the other side as a pull-down request. The side that went low first owns the pair. The echo that this pull-down causes on the far side is masked for a short guard window, so the pair cannot hold itself low.

Top module: `hsbus_join_seq`

## Requirements
- R1: While `en_i` is low, `ready_o`, `precharge_o`, `link_o` and all four pull outputs are 0, and lows on the bus inputs are not forwarded to any pull output.
- R2: On the first rising edge that samples `en_i` high in the off state, the block enters initialisation: after that edge `precharge_o` is 1 and `ready_o` and `link_o` are 0.
- R3: The STOP/idle watch begins only after INIT_CYC cycles of initialisation. A STOP seen during initialisation does not cause a join. With all lines high throughout, `link_o` first reads 1 after rising edge number INIT_CYC+IDLE_CYC+1, counting the edge that first sampled `en_i` high as edge 1.
- R4: In the watch state, a join through the idle path needs IDLE_CYC consecutive cycles with all four synchronised lines high. A synchronised low on any line restarts the count from zero.
- R5: In the watch state, a STOP (the synchronised backplane data line going 0 to 1 while the synchronised backplane clock line is 1 on both samples) joins the segments if all lines are high. `link_o` reads 1 after the third rising edge, counting the edge that first samples the risen data input as edge 1.
- R6: At the join, `precharge_o` falls in the same cycle that `link_o` and `ready_o` rise. `precharge_o` is 1 throughout initialisation and watch.
- R7: Sampling `en_i` low in any state returns the block to the off state after that one edge and clears its counters. A later enable repeats the full initialisation and idle timing.
- R8: While joined, a low on one line of a pair (pair 0 is clock, pair 1 is data) asserts the pull output of the other segment's line of that pair after the third rising edge that sees it. The pull releases after the third edge that sees the line high again.
- R9: After the owning side releases, the echo on the far side is ignored for SYNC_STAGES+1 cycles. The pair then returns to both pulls 0. The two pull outputs of a pair are never 1 together.
- R10: If both lines of a pair are first sampled low in the same cycle, the backplane side wins: only the card-side pull output of that pair asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low forces the off state |
| bp_scl_i | input | 1 | Sampled level of backplane clock line |
| bp_sda_i | input | 1 | Sampled level of backplane data line |
| cd_scl_i | input | 1 | Sampled level of card clock line |
| cd_sda_i | input | 1 | Sampled level of card data line |
| ready_o | output | 1 | 1 when the segments are joined |
| precharge_o | output | 1 | Precharge control, on during initialisation and watch |
| link_o | output | 1 | Connect control for the bus buffers |
| bp_scl_pull_o | output | 1 | Request to pull backplane clock low |
| bp_sda_pull_o | output | 1 | Request to pull backplane data low |
| cd_scl_pull_o | output | 1 | Request to pull card clock low |
| cd_sda_pull_o | output | 1 | Request to pull card data low |

## Verification
A wrong sequencer state shows up as `link_o` or `precharge_o` changing on the wrong edge. The bench pins the join to one exact cycle on the idle path, on the STOP path and after a restart of the idle count, so an error of even one cycle is reported at that edge. A wrong owner in a mirrored pair shows within three edges as a pull output on the wrong side. A missing echo guard shows a few cycles after release as a pull that never drops, because the bench folds each pull back into its line the way a wired-AND bus would.

// File: rtl/hsj_pkg.sv
package hsj_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF   = 2'd0,
    SEQ_INIT  = 2'd1,
    SEQ_WATCH = 2'd2,
    SEQ_LINK  = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    MIR_IDLE  = 3'd0,
    MIR_A     = 3'd1,
    MIR_B     = 3'd2,
    MIR_A_REL = 3'd3,
    MIR_B_REL = 3'd4
  } mir_state_t;

  // Counter width able to hold the value n.
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Data rises while clock stays high over both samples.
  function automatic logic stop_event(input logic sda_now, input logic sda_prev,
                                      input logic scl_now, input logic scl_prev);
    return sda_now & ~sda_prev & scl_now & scl_prev;
  endfunction

endpackage

// File: rtl/hsj_sync.sv
module hsj_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hsj_ctrl.sv
module hsj_ctrl
  import hsj_pkg::*;
#(
  parameter int INIT_CYC = 16,
  parameter int IDLE_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [3:0] lines_i,     // {cd_sda, cd_scl, bp_sda, bp_scl}, synchronised
  output logic       precharge_o,
  output logic       link_o
);
  localparam int MAXC = (INIT_CYC > IDLE_CYC) ? INIT_CYC : IDLE_CYC;
  localparam int CW   = cnt_bits(MAXC);

  seq_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          bp_scl_q, bp_sda_q;

  // Named internal events.
  logic all_hi_w, stop_w, init_done_w, idle_done_w, join_w;

  assign all_hi_w    = &lines_i;
  assign stop_w      = stop_event(lines_i[1], bp_sda_q, lines_i[0], bp_scl_q);
  assign init_done_w = (cnt_q == CW'(INIT_CYC - 1));
  assign idle_done_w = (cnt_q == CW'(IDLE_CYC - 1));
  assign join_w      = all_hi_w && (stop_w || idle_done_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_scl_q <= 1'b0;
      bp_sda_q <= 1'b0;
    end else begin
      bp_scl_q <= lines_i[0];
      bp_sda_q <= lines_i[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_OFF;
      cnt_q <= '0;
    end else if (!en_i) begin
      st_q  <= SEQ_OFF;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SEQ_OFF: begin
          st_q  <= SEQ_INIT;
          cnt_q <= '0;
        end
        SEQ_INIT: begin
          if (init_done_w) begin
            st_q  <= SEQ_WATCH;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        SEQ_WATCH: begin
          if (join_w) begin
            st_q  <= SEQ_LINK;
            cnt_q <= '0;
          end else if (!all_hi_w) begin
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= SEQ_LINK;
      endcase
    end
  end

  assign precharge_o = (st_q == SEQ_INIT) || (st_q == SEQ_WATCH);
  assign link_o      = (st_q == SEQ_LINK);

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == SEQ_OFF && cnt_q == '0)); // R7
  AST_WATCH_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WATCH && $past(st_q) != SEQ_WATCH) |->
      ($past(st_q) == SEQ_INIT && $past(cnt_q) == CW'(INIT_CYC - 1))); // R3
  AST_JOIN_FROM_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> ($past(st_q) == SEQ_WATCH && $past(all_hi_w))); // R4
  AST_PRECHARGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> $fell(precharge_o)); // R6
endmodule

// File: rtl/hsj_mirror.sv
module hsj_mirror
  import hsj_pkg::*;
#(
  parameter int GUARD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  input  logic a_low_i,   // backplane side low, synchronised
  input  logic b_low_i,   // card side low, synchronised
  output logic pull_a_o,
  output logic pull_b_o
);
  localparam int GW = cnt_bits(GUARD);

  mir_state_t    st_q;
  logic [GW-1:0] g_q;
  logic          guard_done_w;

  assign guard_done_w = (g_q == GW'(GUARD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MIR_IDLE;
      g_q  <= '0;
    end else if (!link_i) begin
      st_q <= MIR_IDLE;
      g_q  <= '0;
    end else begin
      case (st_q)
        MIR_IDLE: begin
          if (a_low_i)      st_q <= MIR_A;
          else if (b_low_i) st_q <= MIR_B;
        end
        MIR_A: if (!a_low_i) begin st_q <= MIR_A_REL; g_q <= '0; end
        MIR_B: if (!b_low_i) begin st_q <= MIR_B_REL; g_q <= '0; end
        MIR_A_REL: begin
          if (a_low_i)           st_q <= MIR_A;
          else if (guard_done_w) st_q <= MIR_IDLE;
          else                   g_q  <= g_q + GW'(1);
        end
        MIR_B_REL: begin
          if (b_low_i)           st_q <= MIR_B;
          else if (guard_done_w) st_q <= MIR_IDLE;
          else                   g_q  <= g_q + GW'(1);
        end
        default: st_q <= MIR_IDLE;
      endcase
    end
  end

  assign pull_b_o = link_i && (st_q == MIR_A);
  assign pull_a_o = link_i && (st_q == MIR_B);

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_a_o && pull_b_o)); // R9
  AST_MIRROR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && st_q == MIR_IDLE && a_low_i) |=> (pull_b_o || !link_i)); // R8
  AST_BP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && st_q == MIR_IDLE && a_low_i && b_low_i) |=> !pull_a_o); // R10
endmodule

// File: rtl/hsbus_join_seq.sv
module hsbus_join_seq #(
  parameter int INIT_CYC    = 16,
  parameter int IDLE_CYC    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bp_scl_i,
  input  logic bp_sda_i,
  input  logic cd_scl_i,
  input  logic cd_sda_i,
  output logic ready_o,
  output logic precharge_o,
  output logic link_o,
  output logic bp_scl_pull_o,
  output logic bp_sda_pull_o,
  output logic cd_scl_pull_o,
  output logic cd_sda_pull_o
);
  localparam int NPAIR = 2;                 // 0 = clock, 1 = data
  localparam int GUARD = SYNC_STAGES + 1;   // echo mask window

  logic [3:0]       lines_s;
  logic             link_w;
  logic [NPAIR-1:0] bp_low, cd_low, bp_pull, cd_pull;

  hsj_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cd_sda_i, cd_scl_i, bp_sda_i, bp_scl_i}),
    .q_o   (lines_s)
  );

  hsj_ctrl #(.INIT_CYC(INIT_CYC), .IDLE_CYC(IDLE_CYC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .lines_i     (lines_s),
    .precharge_o (precharge_o),
    .link_o      (link_w)
  );

  assign bp_low = ~lines_s[1:0];
  assign cd_low = ~lines_s[3:2];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    hsj_mirror #(.GUARD(GUARD)) u_mir (
      .clk      (clk),
      .rst_n    (rst_n),
      .link_i   (link_w),
      .a_low_i  (bp_low[p]),
      .b_low_i  (cd_low[p]),
      .pull_a_o (bp_pull[p]),
      .pull_b_o (cd_pull[p])
    );
  end

  assign link_o        = link_w;
  assign ready_o       = link_w;
  assign bp_scl_pull_o = bp_pull[0];
  assign bp_sda_pull_o = bp_pull[1];
  assign cd_scl_pull_o = cd_pull[0];
  assign cd_sda_pull_o = cd_pull[1];

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(ready_o || precharge_o || |bp_pull || |cd_pull)); // R1
  AST_INIT_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!precharge_o && !link_o && en_i) |=> (precharge_o && !ready_o)); // R2
endmodule

// File: tb/hsbus_join_seq_tb_top.sv
module hsbus_join_seq_tb_top;
  localparam int INIT = 16;
  localparam int IDLE = 24;
  localparam logic [6:0] ALL = 7'h7F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic bp_scl_drv = 1'b1, bp_sda_drv = 1'b1, cd_scl_drv = 1'b1, cd_sda_drv = 1'b1;
  logic ready_o, precharge_o, link_o;
  logic bp_scl_pull_o, bp_sda_pull_o, cd_scl_pull_o, cd_sda_pull_o;
  logic bp_scl_ln, bp_sda_ln, cd_scl_ln, cd_sda_ln;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int         q_cyc[$];
  logic [6:0] q_mask[$];
  logic [6:0] q_val[$];
  string      q_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Wired-AND bus model: a pull request drags the line low.
  assign bp_scl_ln = bp_scl_drv & ~bp_scl_pull_o;
  assign bp_sda_ln = bp_sda_drv & ~bp_sda_pull_o;
  assign cd_scl_ln = cd_scl_drv & ~cd_scl_pull_o;
  assign cd_sda_ln = cd_sda_drv & ~cd_sda_pull_o;

  hsbus_join_seq #(.INIT_CYC(INIT), .IDLE_CYC(IDLE), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .bp_scl_i(bp_scl_ln), .bp_sda_i(bp_sda_ln),
    .cd_scl_i(cd_scl_ln), .cd_sda_i(cd_sda_ln),
    .ready_o(ready_o), .precharge_o(precharge_o), .link_o(link_o),
    .bp_scl_pull_o(bp_scl_pull_o), .bp_sda_pull_o(bp_sda_pull_o),
    .cd_scl_pull_o(cd_scl_pull_o), .cd_sda_pull_o(cd_sda_pull_o)
  );

  // Observed vector: ready, precharge, link, bp_scl, bp_sda, cd_scl, cd_sda pulls.
  function automatic logic [6:0] obs();
    return {ready_o, precharge_o, link_o, bp_scl_pull_o, bp_sda_pull_o,
            cd_scl_pull_o, cd_sda_pull_o};
  endfunction

  // Expected join edge on the idle path, counted from the enable edge.
  function automatic int idle_join(input int en_cyc);
    return en_cyc + INIT + IDLE + 1;
  endfunction

  task automatic expect_at(input int c, input logic [6:0] m, input logic [6:0] v,
                           input string tag);
    int idx = q_cyc.size();
    for (int i = 0; i < q_cyc.size(); i++) begin
      if (q_cyc[i] > c) begin idx = i; break; end
    end
    q_cyc.insert(idx, c);
    q_mask.insert(idx, m);
    q_val.insert(idx, v);
    q_tag.insert(idx, tag);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pop and compare away from the active edge.
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      if (q_cyc[0] < cyc || ((obs() & q_mask[0]) != (q_val[0] & q_mask[0]))) begin
        failures++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                 q_tag[0], cyc, obs() & q_mask[0], q_val[0] & q_mask[0], q_mask[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_mask.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0, cl, c1, c1b, c2, c3, c4, c5, c6, c7;
    @(negedge clk);
    wait_to(3);
    rst_n = 1'b1;
    bp_scl_drv = 1'b0;
    expect_at(5, ALL, 7'b0000000, "R1 reset state, disabled");
    expect_at(8, ALL, 7'b0000000, "R1 low not forwarded while disabled");
    wait_to(9);
    bp_scl_drv = 1'b1;

    // Idle-path join.
    c0 = 12;
    wait_to(c0);
    en = 1'b1;
    expect_at(c0 + 1, 7'h70, 7'b0100000, "R2 init after enable");
    expect_at(idle_join(c0) - 1, 7'h70, 7'b0100000, "R3 no early join");
    expect_at(idle_join(c0), ALL, 7'b1010000, "R6 join drops precharge");
    cl = idle_join(c0);

    // Mirroring, backplane data to card data.
    wait_to(cl + 2);
    bp_sda_drv = 1'b0;
    expect_at(cl + 4, 7'h0F, 7'b0000000, "R8 latency not yet");
    expect_at(cl + 5, 7'h0F, 7'b0000001, "R8 bp data pulls card data");
    wait_to(cl + 8);
    bp_sda_drv = 1'b1;
    expect_at(cl + 10, 7'h0F, 7'b0000001, "R8 pull held");
    expect_at(cl + 11, 7'h0F, 7'b0000000, "R8 pull released");
    expect_at(cl + 14, 7'h1F, 7'b0010000, "R9 echo ignored");
    expect_at(cl + 20, 7'h1F, 7'b0010000, "R9 no latch data");

    // Card clock to backplane clock.
    wait_to(cl + 22);
    cd_scl_drv = 1'b0;
    expect_at(cl + 25, 7'h0F, 7'b0001000, "R8 card clock pulls bp clock");
    wait_to(cl + 30);
    cd_scl_drv = 1'b1;
    expect_at(cl + 36, 7'h1F, 7'b0010000, "R9 no latch clock");

    // Simultaneous low: backplane wins.
    wait_to(cl + 40);
    bp_sda_drv = 1'b0;
    cd_sda_drv = 1'b0;
    expect_at(cl + 43, 7'h0F, 7'b0000001, "R10 backplane priority");
    wait_to(cl + 46);
    bp_sda_drv = 1'b1;
    cd_sda_drv = 1'b1;
    expect_at(cl + 52, 7'h1F, 7'b0010000, "R9 pair clean");

    // Disable in watch, then full re-init.
    c1 = cl + 60;
    wait_to(c1);
    en = 1'b0;
    expect_at(c1 + 1, ALL, 7'b0000000, "R7 disable from link");
    wait_to(c1 + 3);
    en = 1'b1;
    wait_to(c1 + 3 + INIT + 10);
    en = 1'b0;
    expect_at(c1 + 3 + INIT + 11, ALL, 7'b0000000, "R7 disable from watch");
    c1b = c1 + 3 + INIT + 12;
    wait_to(c1b);
    en = 1'b1;
    expect_at(idle_join(c1b) - 1, 7'h10, 7'b0000000, "R7 counters cleared");
    expect_at(idle_join(c1b), 7'h10, 7'b0010000, "R7 rejoin");

    // STOP path.
    c2 = idle_join(c1b) + 5;
    wait_to(c2);
    en = 1'b0;
    bp_sda_drv = 1'b0;
    c3 = c2 + 2;
    wait_to(c3);
    en = 1'b1;
    wait_to(c3 + INIT + 4);
    bp_sda_drv = 1'b1;
    expect_at(c3 + INIT + 6, 7'h70, 7'b0100000, "R5 stop not yet");
    expect_at(c3 + INIT + 7, 7'h70, 7'b1010000, "R5 stop joins");

    // STOP during init is ignored.
    c4 = c3 + INIT + 12;
    wait_to(c4);
    en = 1'b0;
    bp_sda_drv = 1'b0;
    c5 = c4 + 2;
    wait_to(c5);
    en = 1'b1;
    wait_to(c5 + 3);
    bp_sda_drv = 1'b1;
    expect_at(idle_join(c5) - 1, 7'h10, 7'b0000000, "R3 stop in init ignored");
    expect_at(idle_join(c5), 7'h10, 7'b0010000, "R3 join after idle");

    // Idle count restart.
    c6 = idle_join(c5) + 5;
    wait_to(c6);
    en = 1'b0;
    c7 = c6 + 2;
    wait_to(c7);
    en = 1'b1;
    wait_to(c7 + INIT + 10);
    cd_scl_drv = 1'b0;
    wait_to(c7 + INIT + 11);
    cd_scl_drv = 1'b1;
    expect_at(idle_join(c7), 7'h10, 7'b0000000, "R4 restart delays join");
    expect_at(c7 + INIT + IDLE + 12, 7'h10, 7'b0000000, "R4 still waiting");
    expect_at(c7 + INIT + IDLE + 13, 7'h10, 7'b0010000, "R4 join after restart");

    wait_to(c7 + INIT + IDLE + 20);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule